// File: doc/BRIEF.md
# MDIO Management Frame Master

This block drives one clause-22 management access on the two-wire serial management bus of an Ethernet PHY each time it is started. A single-cycle start strobe captures the direction (read or write), a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of payload. The block then clocks out a 64-bit frame on its own management clock: 32 idle ones, a 16-bit command word and 16 data bits. On a read it lets go of the data line at the turnaround and shifts in the PHY's answer.

The management clock is derived from the system clock. Its half period is the smallest whole number of system clocks that keeps it at or under a configured maximum rate. The data line may only change while the management clock is low. Every bit ends with a rising edge. When the frame is complete the clock rests low, the output enable is released and a one-cycle done pulse is raised. For a read, the assembled word is valid on the read-data port at that point.

Top module: `mdio_master`

## Requirements
- R1: Each access starts with 32 bit periods in which MDO is 1 and the output enable is high.
- R2: Bits 32 to 47 carry the command word, MSB first. The word is 16'h6000 for a read or 16'h5002 for a write, ORed with the PHY address shifted left by 7 and the register address shifted left by 2. This gives start 01, opcode 10 (read) or 01 (write), PHY address, register address and turnaround.
- R3: On a read, the output enable is high for bits 0 to 45 and low from bit 46 (the turnaround) through bit 63.
- R4: On a write, bits 48 to 63 carry the write data MSB first, and the output enable stays high for all 64 bits.
- R5: MDO never changes while MDC stays high. It changes only when MDC falls or while MDC is low.
- R6: On a read, MDI is sampled at the end of the low phase of bits 48 to 63 and assembled MSB first into the read-data port, where it is held. A write leaves the read-data port unchanged.
- R7: Every MDC cycle is HALF clocks low followed by HALF clocks high. An access has exactly 64 rising MDC edges, and afterwards MDC is low.
- R8: A start strobe that arrives while an access is in progress is ignored, together with the address, direction and data presented with it.
- R9: done pulses high for exactly one clock, 128*HALF clocks after the clock edge that accepted the start. The output enable and MDC are both low when done is high.
- R10: HALF is the ceiling of CLK_HZ / (2 * MDC_MAX_HZ). With CLK_HZ = 24 MHz and MDC_MAX_HZ = 2.5 MHz, HALF is 5.
- R11: While reset is asserted, and immediately after it, MDC, the output enable, done and the read data are all 0. This holds even if reset hits in the middle of an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin an access |
| op_read_i | input | 1 | 1 selects read, 0 selects write |
| phy_addr_i | input | 5 | Target PHY address |
| reg_addr_i | input | 5 | Target register address |
| wdata_i | input | 16 | Payload for a write |
| mdi_i | input | 1 | Serial data from the PHY |
| mdc_o | output | 1 | Management clock |
| mdo_o | output | 1 | Serial data toward the PHY |
| mdo_oe_o | output | 1 | Output enable for the bidirectional data pad |
| rdata_o | output | 16 | Last word read from a PHY |
| done_o | output | 1 | One-cycle pulse at the end of an access |

## Verification
The hardest case to reach is a start request that lands while a frame is already being shifted. The block gives no busy indication, so nothing at the ports shows that the request was dropped except the frame bits themselves. The bench therefore issues a second strobe with a different address, direction and payload in the middle of a read. It then checks that all 64 captured bit periods, the output-enable pattern, the read word and the total cycle count still match the first request. A PHY model in the bench drives MDI from the count of rising MDC edges. This lets it present the turnaround zero and each answer bit exactly in the bit period the master samples.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int PRE_BITS   = 32;
    localparam int CMD_BITS   = 16;
    localparam int DATA_BITS  = 16;
    localparam int FRAME_BITS = PRE_BITS + CMD_BITS + DATA_BITS;
    localparam int IDX_W      = $clog2(FRAME_BITS);

    // first bit period in which a read frees the data line (turnaround)
    localparam int TA_FIRST   = PRE_BITS + CMD_BITS - 2;
    // first bit period carrying data
    localparam int DATA_FIRST = PRE_BITS + CMD_BITS;

    localparam logic [CMD_BITS-1:0] CMD_RD_BASE = 16'h6000;
    localparam logic [CMD_BITS-1:0] CMD_WR_BASE = 16'h5002;

    typedef enum logic {
        MM_IDLE = 1'b0,
        MM_RUN  = 1'b1
    } mm_state_e;

    typedef struct packed {
        mm_state_e               state;
        logic                    is_read;
        logic [IDX_W-1:0]        bit_idx;
        logic                    mdc;
        logic                    oe;
        logic                    done;
        logic [FRAME_BITS-1:0]   frame;
        logic [DATA_BITS-1:0]    rdata;
    } mm_regs_t;

endpackage

// File: rtl/mdio_half_timer.sv
module mdio_half_timer #(
    parameter int HALF = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);

    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && (cnt_q == LAST);
        if (!run_i || tick_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/mdio_frame_build.sv
module mdio_frame_build
    import mdio_pkg::*;
(
    input  logic                  op_read_i,
    input  logic [4:0]            phy_addr_i,
    input  logic [4:0]            reg_addr_i,
    input  logic [DATA_BITS-1:0]  wdata_i,
    output logic [FRAME_BITS-1:0] frame_o
);

    logic [CMD_BITS-1:0] cmd;
    logic [DATA_BITS-1:0] tail;

    always_comb begin
        cmd  = (op_read_i ? CMD_RD_BASE : CMD_WR_BASE)
             | {4'b0, phy_addr_i, 7'b0}
             | {9'b0, reg_addr_i, 2'b0};
        // a read does not drive the data field; ones keep the line idle-high
        tail = op_read_i ? {DATA_BITS{1'b1}} : wdata_i;
        frame_o = {{PRE_BITS{1'b1}}, cmd, tail};
    end

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int CLK_HZ     = 50_000_000,
    parameter int MDC_MAX_HZ = 2_500_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        op_read_i,
    input  logic [4:0]  phy_addr_i,
    input  logic [4:0]  reg_addr_i,
    input  logic [15:0] wdata_i,
    input  logic        mdi_i,
    output logic        mdc_o,
    output logic        mdo_o,
    output logic        mdo_oe_o,
    output logic [15:0] rdata_o,
    output logic        done_o
);

    localparam int HALF_CLKS = (CLK_HZ + 2 * MDC_MAX_HZ - 1) / (2 * MDC_MAX_HZ);
    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] TA_IDX    = IDX_W'(TA_FIRST);
    localparam logic [IDX_W-1:0] DATA_IDX  = IDX_W'(DATA_FIRST);

    mm_regs_t r_d, r_q;
    logic tick;
    logic [FRAME_BITS-1:0] new_frame;

    mdio_half_timer #(.HALF(HALF_CLKS)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (r_q.state == MM_RUN),
        .tick_o (tick)
    );

    mdio_frame_build u_build (
        .op_read_i  (op_read_i),
        .phy_addr_i (phy_addr_i),
        .reg_addr_i (reg_addr_i),
        .wdata_i    (wdata_i),
        .frame_o    (new_frame)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.state)
            MM_IDLE: begin
                if (start_i) begin
                    r_d.state   = MM_RUN;
                    r_d.is_read = op_read_i;
                    r_d.bit_idx = '0;
                    r_d.mdc     = 1'b0;
                    r_d.oe      = 1'b1;
                    r_d.frame   = new_frame;
                end
            end
            MM_RUN: begin
                if (tick) begin
                    if (!r_q.mdc) begin
                        // end of low phase: raise clock, sample PHY data
                        r_d.mdc = 1'b1;
                        if (r_q.is_read && r_q.bit_idx >= DATA_IDX) begin
                            r_d.rdata = {r_q.rdata[DATA_BITS-2:0], mdi_i};
                        end
                    end else begin
                        // end of high phase: drop clock, advance bit
                        r_d.mdc = 1'b0;
                        if (r_q.bit_idx == LAST_IDX) begin
                            r_d.state = MM_IDLE;
                            r_d.oe    = 1'b0;
                            r_d.done  = 1'b1;
                        end else begin
                            r_d.bit_idx = r_q.bit_idx + IDX_W'(1);
                            r_d.frame   = {r_q.frame[FRAME_BITS-2:0], 1'b1};
                            if (r_q.is_read && (r_q.bit_idx + IDX_W'(1)) == TA_IDX) begin
                                r_d.oe = 1'b0;
                            end
                        end
                    end
                end
            end
            default: r_d.state = MM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: MM_IDLE, is_read: 1'b0, bit_idx: '0, mdc: 1'b0,
                     oe: 1'b0, done: 1'b0, frame: '1, rdata: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign mdc_o    = r_q.mdc;
    assign mdo_o    = r_q.frame[FRAME_BITS-1];
    assign mdo_oe_o = r_q.oe;
    assign rdata_o  = r_q.rdata;
    assign done_o   = r_q.done;

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
    parameter int HALF = 10
) (
    input logic clk,
    input logic rst_n,
    input logic mdc,
    input logic mdo,
    input logic oe,
    input logic done
);

    int hi_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_len <= 0;
        end else begin
            hi_len <= mdc ? hi_len + 1 : 0;
        end
    end

    // R5: data line held through the high phase
    p_mdo_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |=> (!mdc || $stable(mdo)));

    // R9: done lasts one clock
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: bus at rest when done is raised
    p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!mdc && !oe));

    // R7: every high phase lasts HALF clocks
    p_high_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mdc) |-> (hi_len == HALF));

    // R3: the data line is released only while the clock is low
    p_oe_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe) |-> !mdc);

endmodule

bind mdio_master mdio_master_chk #(.HALF(HALF_CLKS)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .mdc   (mdc_o),
    .mdo   (mdo_o),
    .oe    (mdo_oe_o),
    .done  (done_o)
);

// File: tb/mdio_master_tb.sv
module mdio_master_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int T_CLK_HZ   = 24_000_000;
    localparam int T_MDC_HZ   = 2_500_000;
    localparam int EXP_HALF   = 5;      // R10: ceil(24/5)
    localparam int EXP_CYC    = 128 * EXP_HALF + 1;
    localparam int NVEC       = 6;

    // {read, phy, reg, wdata, phy_answer}
    localparam logic [42:0] VEC [NVEC] = '{
        {1'b1, 5'h01, 5'h01, 16'h0000, 16'hA5C3},
        {1'b0, 5'h1F, 5'h1F, 16'hFFFF, 16'h0000},
        {1'b1, 5'h00, 5'h00, 16'h0000, 16'h0001},
        {1'b0, 5'h10, 5'h04, 16'h8001, 16'h0000},
        {1'b1, 5'h15, 5'h0A, 16'h0000, 16'hFFFF},
        {1'b0, 5'h00, 5'h00, 16'h0000, 16'h0000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic op_read = 1'b0;
    logic [4:0] phy = '0;
    logic [4:0] rga = '0;
    logic [15:0] wdata = '0;
    logic mdi;
    logic mdc, mdo, oe, done;
    logic [15:0] rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // monitor state
    bit   mon_clr = 1'b1;
    int   rises;
    logic mdo_cap [64];
    logic oe_cap  [64];
    int   hi_run;
    bit   hi_bad, r5_bad;
    logic prev_mdc, prev_mdo;
    logic [15:0] cur_pv = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mdio_master #(.CLK_HZ(T_CLK_HZ), .MDC_MAX_HZ(T_MDC_HZ)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .op_read_i  (op_read),
        .phy_addr_i (phy),
        .reg_addr_i (rga),
        .wdata_i    (wdata),
        .mdi_i      (mdi),
        .mdc_o      (mdc),
        .mdo_o      (mdo),
        .mdo_oe_o   (oe),
        .rdata_o    (rdata),
        .done_o     (done)
    );

    // PHY model: turnaround 0 in bit 47, answer bits 48..63
    assign mdi = (rises >= 48 && rises < 64) ? cur_pv[63 - rises]
               : ((rises == 47) ? 1'b0 : 1'b1);

    always @(negedge clk) begin
        if (mon_clr) begin
            rises = 0; hi_run = 0; hi_bad = 0; r5_bad = 0;
        end else begin
            if (mdc && !prev_mdc) begin
                if (rises < 64) begin
                    mdo_cap[rises] = mdo;
                    oe_cap[rises]  = oe;
                end
                rises++;
            end
            if (mdc && prev_mdc && mdo !== prev_mdo) r5_bad = 1;
            if (mdc) hi_run++;
            else begin
                if (prev_mdc && hi_run != EXP_HALF) hi_bad = 1;
                hi_run = 0;
            end
        end
        prev_mdc = mdc;
        prev_mdo = mdo;
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_txn(input logic [42:0] v, input bit inject);
        logic rd;
        logic [4:0] p, r;
        logic [15:0] wd, pv, cmd, rd_before;
        logic [63:0] exp_frame, got_mdo, got_oe, exp_oe;
        int cyc;
        bit seen;
        {rd, p, r, wd, pv} = v;
        cmd = (rd ? 16'h6000 : 16'h5002) | (16'(p) << 7) | (16'(r) << 2);
        exp_frame = {32'hFFFF_FFFF, cmd, wd};
        exp_oe = rd ? {46'h3FFF_FFFF_FFFF, 18'h0} : 64'hFFFF_FFFF_FFFF_FFFF;
        rd_before = rdata;
        @(negedge clk); #1;
        mon_clr = 1'b1; cur_pv = pv;
        @(negedge clk); #1;
        mon_clr = 1'b0;
        op_read = rd; phy = p; rga = r; wdata = wd; start = 1'b1;
        cyc = 0; seen = 0;
        while (!seen && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (done) seen = 1;
            #1;
            if (cyc == 1) start = 1'b0;
            if (inject && cyc == 200) begin
                // R8: conflicting request mid-frame
                start = 1'b1; op_read = ~rd; phy = ~p; rga = ~r; wdata = ~wd;
            end
            if (inject && cyc == 201) start = 1'b0;
        end
        check(seen && cyc == EXP_CYC, inject ? "R8/R9 cycles" : "R9 cycles",
              64'(cyc), 64'(EXP_CYC));
        @(negedge clk);
        check(!done, "R9 done one clock", 64'(done), 64'd0);
        check(!mdc && !oe, "R7 idle mdc/oe low", {62'd0, mdc, oe}, 64'd0);
        check(rises == 64, "R7 rising edges", 64'(rises), 64'd64);
        check(!hi_bad, "R7/R10 high phase length", 64'(hi_bad), 64'd0);
        check(!r5_bad, "R5 mdo stable while mdc high", 64'(r5_bad), 64'd0);
        for (int i = 0; i < 64; i++) begin
            got_mdo[63 - i] = mdo_cap[i];
            got_oe[63 - i]  = oe_cap[i];
        end
        check(got_mdo[63:32] == 32'hFFFF_FFFF && got_oe[63:32] == 32'hFFFF_FFFF,
              "R1 preamble", got_mdo, exp_frame);
        check(got_oe == exp_oe, rd ? "R3 oe pattern" : "R4 oe held", got_oe, exp_oe);
        if (rd) begin
            check(got_mdo[31:18] == exp_frame[31:18], "R2 command word",
                  64'(got_mdo[31:18]), 64'(exp_frame[31:18]));
            check(rdata == pv, "R6 read data", 64'(rdata), 64'(pv));
        end else begin
            check(got_mdo[31:16] == cmd, "R2 command word",
                  64'(got_mdo[31:16]), 64'(cmd));
            check(got_mdo[15:0] == wd, "R4 write data",
                  64'(got_mdo[15:0]), 64'(wd));
            check(rdata == rd_before, "R6 write keeps rdata",
                  64'(rdata), 64'(rd_before));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R11: reset state, start ignored in reset
        start = 1'b1; op_read = 1'b1;
        repeat (3) @(negedge clk);
        check(!mdc && !oe && !done && rdata == 16'h0, "R11 reset state",
              {45'd0, mdc, oe, done, rdata}, 64'd0);
        #1; start = 1'b0; rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!mdc && !oe && !done, "R11 after reset idle",
              {61'd0, mdc, oe, done}, 64'd0);

        // vector table
        for (int k = 0; k < NVEC; k++) run_txn(VEC[k], 1'b0);

        // R8: mid-frame start ignored (read, then write vector)
        run_txn({1'b1, 5'h0C, 5'h13, 16'h0000, 16'h3C5A}, 1'b1);
        run_txn({1'b0, 5'h03, 5'h1C, 16'h6B2D, 16'h0000}, 1'b1);

        // R11: reset in mid access
        @(negedge clk); #1;
        op_read = 1'b0; start = 1'b1;
        @(negedge clk); #1; start = 1'b0;
        repeat (100) @(negedge clk);
        #1; rst_n = 1'b0;
        @(negedge clk);
        check(!mdc && !oe && !done && rdata == 16'h0, "R11 reset mid access",
              {45'd0, mdc, oe, done, rdata}, 64'd0);
        #1; rst_n = 1'b1;
        repeat (4 * EXP_HALF) @(negedge clk);
        check(!mdc && !oe, "R11 stays idle after reset", {62'd0, mdc, oe}, 64'd0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule